// File: doc/BRIEF.md
# Configurable Registered Buffer with Chip-Select Gating

This block is a bank of rising-edge data flops that sits between a command/address source and a wide set of destination loads. It runs in one of two arrangements that can be changed while it is running. In the flat arrangement, each of 25 input bits is registered onto the output with the same index. In the duplicated arrangement, 14 input bits are registered and each one drives two output bits, one in the low half and one in the high half of a 28-bit output bus. A second select input picks which 14 input positions feed the duplicated arrangement.

Two select inputs act together as an update gate. When both are high, the outputs keep their values across the clock edge. When either one is low, the outputs load new data. An active-low reset clears the outputs at once, whatever the gate inputs are doing. Its release is synchronised to the clock, so the outputs stay low for a fixed number of edges after release before the first capture. Mode and gate inputs are sampled on the same edge as the data, so the outputs only ever change at a rising clock edge or when reset is asserted.

Top module: `cfgbuf_top`

## Requirements
- R1: With `dup_mode_i` low, on each updating edge `q_o[k]` takes `d_i[k]` for k = 0..24, and `q_o[27:25]` is driven to 0.
- R2: With `dup_mode_i` high, on each updating edge `q_o[k]` and `q_o[k+14]` take the same captured bit, for k = 0..13.
- R3: In the duplicated arrangement with `alt_map_i` low, the source of `q_o[k]` and `q_o[k+14]` is `d_i[k]`.
- R4: In the duplicated arrangement with `alt_map_i` high, the source of `q_o[k]` and `q_o[k+14]` is `d_i[k+11]`, so input bits 11..24 are used.
- R5: Outputs change only at a rising clock edge: a change of `d_i`, `dup_mode_i` or `alt_map_i` between edges has no effect on `q_o` until the next rising edge.
- R6: When `gate_a_i` and `gate_b_i` are both high at a rising edge, `q_o` keeps its previous value across that edge.
- R7: When `gate_a_i` or `gate_b_i` is low at a rising edge, `q_o` loads the mapped input on that edge.
- R8: While `rst_n` is low, `q_o` is all zero without waiting for a clock edge, whatever the values of `gate_a_i` and `gate_b_i`.
- R9: After `rst_n` rises, `q_o` stays all zero through the first two rising edges, whatever the inputs are, and the third rising edge is the first one that captures.
- R10: With `dup_mode_i` low, the value of `alt_map_i` has no effect on `q_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| dup_mode_i | input | 1 | 0: 25-bit flat arrangement, 1: 14-bit duplicated arrangement |
| alt_map_i | input | 1 | In the duplicated arrangement, 0: source bits 0..13, 1: source bits 11..24 |
| gate_a_i | input | 1 | Update gate; the outputs hold only when this and gate_b_i are both high |
| gate_b_i | input | 1 | Second update gate input |
| d_i | input | 25 | Data inputs |
| q_o | output | 28 | Registered outputs |

## Verification
The two functions that can act in the same cycle are the asynchronous clear and the both-high hold of the update gate. Reset does not have to land on a clock edge, so both can act between the same pair of edges. The bench drives the gate inputs high with non-zero data held in the outputs, then pulls reset low in the middle of a clock period and samples `q_o` before the next edge. The outputs must read zero, because the clear takes priority over the hold. The bench then releases reset with the gate inputs open and non-zero data applied, and its behavioural model checks that the first two edges still give zero and the third edge captures.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;

  // Arrangement of the output bus, decoded from the two select inputs.
  typedef enum logic [1:0] {
    ARR_FLAT  = 2'd0,
    ARR_DUP_A = 2'd1,
    ARR_DUP_B = 2'd2
  } arrange_e;

  function automatic arrange_e decode_arrange(input logic dup_mode, input logic alt_map);
    arrange_e res;
    if (!dup_mode)    res = ARR_FLAT;
    else if (alt_map) res = ARR_DUP_B;
    else              res = ARR_DUP_A;
    return res;
  endfunction

endpackage

// File: rtl/cfgbuf_rst_sync.sv
module cfgbuf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfgbuf_map.sv
module cfgbuf_map
  import cfgbuf_pkg::*;
#(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14,
  parameter int unsigned OUT_W    = 28
) (
  input  arrange_e          arrange_i,
  input  logic [WIDE_W-1:0] d_i,
  output logic [OUT_W-1:0]  m_o
);

  localparam int unsigned ALT_OFS = WIDE_W - NARROW_W;
  localparam int unsigned DUP_W   = 2 * NARROW_W;

  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    logic flat_v;
    logic dup_a_v;
    logic dup_b_v;

    if (k < WIDE_W) begin : g_flat
      assign flat_v = d_i[k];
    end else begin : g_flat_pad
      assign flat_v = 1'b0;
    end

    if (k < DUP_W) begin : g_dup
      localparam int unsigned SLOT = k % NARROW_W;
      assign dup_a_v = d_i[SLOT];
      assign dup_b_v = d_i[SLOT + ALT_OFS];
    end else begin : g_dup_pad
      assign dup_a_v = 1'b0;
      assign dup_b_v = 1'b0;
    end

    always_comb begin
      unique case (arrange_i)
        ARR_DUP_A: m_o[k] = dup_a_v;
        ARR_DUP_B: m_o[k] = dup_b_v;
        default:   m_o[k] = flat_v;
      endcase
    end
  end

endmodule

// File: rtl/cfgbuf_store.sv
module cfgbuf_store #(
  parameter int unsigned W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q_o;
    if (upd_en) q_next = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

  // R6: a closed gate keeps the stored word across the edge
  a_r6_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(q_o));

  // R7: an open gate loads the presented word
  a_r7_load_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (q_o == $past(d_i)));

endmodule

// File: rtl/cfgbuf_top.sv
module cfgbuf_top
  import cfgbuf_pkg::*;
#(
  parameter int unsigned WIDE_W      = 25,
  parameter int unsigned NARROW_W    = 14,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DUP_W      = 2 * NARROW_W,
  localparam int unsigned OUT_W      = (WIDE_W > DUP_W) ? WIDE_W : DUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dup_mode_i,
  input  logic              alt_map_i,
  input  logic              gate_a_i,
  input  logic              gate_b_i,
  input  logic [WIDE_W-1:0] d_i,
  output logic [OUT_W-1:0]  q_o
);

  logic        rst_sync_n;
  logic        upd_en;
  arrange_e    arrange;
  logic [OUT_W-1:0] mapped;

  cfgbuf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    arrange = decode_arrange(dup_mode_i, alt_map_i);
    upd_en  = !(gate_a_i && gate_b_i);
  end

  cfgbuf_map #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W),
    .OUT_W    (OUT_W)
  ) u_map (
    .arrange_i (arrange),
    .d_i       (d_i),
    .m_o       (mapped)
  );

  cfgbuf_store #(.W(OUT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (upd_en),
    .d_i    (mapped),
    .q_o    (q_o)
  );

  // R8: reset low means a cleared output bus, gate inputs notwithstanding
  a_r8_clear_in_reset: assert property (@(posedge clk)
    !rst_n |-> (q_o == '0));

  // R9: no capture while the synchronised release is still pending
  a_r9_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> (q_o == '0));

  // R2: duplicated arrangement drives equal halves
  a_r2_equal_halves: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && dup_mode_i) |=> (q_o[DUP_W-1:NARROW_W] == q_o[NARROW_W-1:0]));

  if (OUT_W > WIDE_W) begin : g_pad_chk
    // R1: flat arrangement leaves the spare top bits at zero
    a_r1_spare_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (upd_en && !dup_mode_i) |=> (q_o[OUT_W-1:WIDE_W] == '0));
  end

endmodule

// File: tb/cfgbuf_top_tb.sv
`timescale 1ns/1ps
module cfgbuf_top_tb;

  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic clk = 1'b0;
  logic rst_n;
  logic dup_mode, alt_map, gate_a, gate_b;
  logic [WW-1:0] d;
  logic [OW-1:0] q;

  logic [OW-1:0] q_exp;
  int rel_cnt;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfgbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .dup_mode_i(dup_mode), .alt_map_i(alt_map),
    .gate_a_i(gate_a), .gate_b_i(gate_b), .d_i(d), .q_o(q)
  );

  function automatic logic [OW-1:0] ref_word(logic [WW-1:0] din, logic dm, logic am);
    logic [OW-1:0] w = '0;
    if (!dm) begin
      for (int k = 0; k < WW; k++) w[k] = din[k];
    end else begin
      for (int k = 0; k < NW; k++) begin
        int src = am ? k + (WW - NW) : k;
        w[k]      = din[src];
        w[k + NW] = din[src];
      end
    end
    return w;
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (q !== q_exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%h expected %h at %0t", tag, q, q_exp, $time);
    end
  endtask

  // One clock: model updates at the edge from the values held since the last negedge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (!rst_n) begin
      q_exp = '0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else if (!(gate_a && gate_b)) begin
      q_exp = ref_word(d, dup_mode, alt_map);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic drive(logic dm, logic am, logic ga, logic gb, logic [WW-1:0] dv);
    dup_mode = dm; alt_map = am; gate_a = ga; gate_b = gb; d = dv;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; q_exp = '0; rel_cnt = 0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk);
    check("R8 reset state");
    tick("R8 reset held");

    // R9: release with non-zero data and open gate
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h1ABCDEF);
    #1 rst_n = 1'b1;
    tick("R9 first edge after release");
    tick("R9 second edge after release");
    tick("R9 first capture");

    // R1 flat arrangement, varied patterns
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 1'b0, i[0], 1'b0, WW'($urandom));
      tick("R1 flat");
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, '1);
    tick("R1 flat all ones");

    // R10: alt select toggled in flat arrangement
    for (int i = 0; i < 10; i++) begin
      drive(1'b0, i[0], 1'b0, 1'b1, WW'($urandom));
      tick("R10 alt ignored in flat");
    end

    // R2/R3 duplicated, mapping A
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom));
      tick("R3 dup map A");
    end
    drive(1'b1, 1'b0, 1'b0, 1'b0, 25'h0003FFF);
    tick("R2 dup low bits only");

    // R4 duplicated, mapping B
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b1, 1'b1, 1'b0, WW'($urandom));
      tick("R4 dup map B");
    end
    drive(1'b1, 1'b1, 1'b0, 1'b0, 25'h1FFC000);
    tick("R4 dup high bits only");

    // R6/R7 gate combinations with changing data and modes
    for (int i = 0; i < 40; i++) begin
      drive(i[3], i[4], i[0], i[1], WW'($urandom));
      tick((i[0] && i[1]) ? "R6 gated hold" : "R7 open update");
    end

    // R5: mid-cycle input change has no effect before the edge
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h0A5A5A5);
    tick("R7 load before R5");
    #1 drive(1'b1, 1'b1, 1'b0, 1'b0, 25'h15A5A5A);
    #1 check("R5 no change between edges");
    tick("R5 change taken at edge");

    // R8 versus R6: reset mid-cycle while both gates high and data held
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h1555555);
    tick("R7 load before reset");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 25'h0FFFFFF);
    tick("R6 hold before reset");
    #2 rst_n = 1'b0;
    q_exp = '0; rel_cnt = 0;
    #1 check("R8 async clear overrides gate");
    tick("R8 held in reset with gate closed");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 25'h0003FFF);
    #1 rst_n = 1'b1;
    tick("R9 edge one after re-release");
    tick("R9 edge two after re-release");
    tick("R9 capture after re-release");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule